// File: doc/BRIEF.md
# Delay-Line Monitor Decision Unit

This block runs periodic measurements on up to five timing-monitor delay lines and turns what it samples into requests to raise or lower the core supply. A two-stage interval timer (a prescaler feeding a wide down-counter) decides when a measurement starts. Optionally a one-cycle priming pulse comes first. Then a launch pulse starts the lines. Each line's three tap outcomes (low, center, high) are captured after that line's own programmable wait. The outcomes of all counted lines are merged into a slow flag and a fast flag. A request and an error picture are then derived from those two flags and held until the next measurement.

The analog delay lines sit outside the block. Each tap outcome arrives as an input bit, where 1 means the launched edge reached that tap before it was sampled. Each line carries its own tap indices, coarse delay selection, wait and active flag. The coarse selection is presented to the lines on a snapshot output. A one-shot mode makes a single measurement and then stops. Dropping the enable returns the block to idle at once.

Top module: `dly_mon_decide`

## Requirements
- R1: After each load the interval counter holds `ivl_cnt` and decrements once every `ivl_pre`+1 clocks. `ivl_zero` is high exactly when it is zero, and is high out of reset. In continuous mode, successive launch pulses are `ivl_cnt`*(`ivl_pre`+1)+7 clocks apart, or one more when priming is enabled. Counter and prescaler are reloaded when each measurement resolves.
- R2: With `one_shot` set, exactly one launch occurs after `mon_en` rises. No further launch occurs while `mon_en` stays high.
- R3: With `prime_en` set, `prime` is high for the single cycle just before each launch. With it clear, `prime` never rises.
- R4: Line i (fields at bits [i*5 +: 5] of the index buses and [i*2 +: 2] of `wait_cfg`) captures its three tap inputs on the clock edge that ends cycle `wait`+1 after the launch cycle. `smp_lo`/`smp_ctr`/`smp_hi` bit i hold the captured values until that line's next capture.
- R5: A line is counted only when its `line_act` bit is set and low index <= center index <= high index. `range_err` is high when some active line breaks that order. `valid_tap` is high when any `line_act` bit is set.
- R6: `slow_trip` is high when any counted line captured a 0 on its low tap.
- R7: `fast_trip` is high when every counted line captured a 1 on its high tap, and at least one line is counted. With `any_hi` set, one counted line with a 1 on its high tap is enough.
- R8: `up_req` equals `slow_trip`. `dn_req` is high when `fast_trip` is set and `slow_trip` is clear. `adj_err` is high when both trip flags are set. All results update on the edge ending the cycle five clocks after the launch cycle, and they hold until the next measurement resolves.
- R9: `ref_ctr` is the captured center tap of the line numbered `ref_sel` at resolve time. `ref_sel` >= 5 drives `ref_err` high (combinationally), and it gives `ref_ctr` = 0.
- R10: `dl_coarse` takes `coarse_cfg` when the interval expires. It stays steady through the measurement that follows, even if `coarse_cfg` changes.
- R11: Reset clears every result, sample, request and pulse output. Dropping `mon_en` returns the block to idle, and no launch occurs while it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitoring enable |
| one_shot | input | 1 | Stop after a single measurement |
| prime_en | input | 1 | Insert priming pulse before launch |
| any_hi | input | 1 | Any single fast line sets the fast flag |
| ref_sel | input | 4 | Reference line number |
| ivl_pre | input | 8 | Interval prescale value |
| ivl_cnt | input | 24 | Interval count value |
| line_act | input | 5 | Per-line active flag |
| lo_idx | input | 25 | Per-line low tap index, 5 bits each |
| ctr_idx | input | 25 | Per-line center tap index |
| hi_idx | input | 25 | Per-line high tap index |
| coarse_cfg | input | 15 | Per-line coarse delay selection, 3 bits each |
| wait_cfg | input | 10 | Per-line launch-to-sample wait, 2 bits each |
| tap_lo | input | 5 | Low tap outcome per line |
| tap_ctr | input | 5 | Center tap outcome per line |
| tap_hi | input | 5 | High tap outcome per line |
| prime | output | 1 | Priming pulse |
| launch | output | 1 | Delay-line launch pulse |
| dl_coarse | output | 15 | Coarse selection snapshot to the lines |
| ivl_zero | output | 1 | Interval counter at zero |
| smp_lo | output | 5 | Last captured low tap per line |
| smp_ctr | output | 5 | Last captured center tap per line |
| smp_hi | output | 5 | Last captured high tap per line |
| slow_trip | output | 1 | Merged slow result |
| fast_trip | output | 1 | Merged fast result |
| ref_ctr | output | 1 | Reference line center-tap result |
| up_req | output | 1 | Raise-supply request |
| dn_req | output | 1 | Lower-supply request |
| adj_err | output | 1 | Raise and lower both indicated |
| range_err | output | 1 | Active line with disordered taps |
| ref_err | output | 1 | Reference select out of range |
| valid_tap | output | 1 | At least one line active |

## Verification
A wrong prescaler or counter state shows as a launch-to-launch gap off by whole prescale periods, and the first gap after enabling already shows it. A wrong wait counter or capture strobe makes `smp_*` take a tap value from the wrong cycle. The bench changes tap inputs mid-measurement so that this becomes visible at the next resolve. A faulty merge, or a line wrongly counted or excluded, shows on the trip and request outputs six cycles after the launch. A scoreboard compares those outputs against an independently computed expectation for every measurement.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COUNT, ST_PRIME, ST_LAUNCH, ST_WAIT, ST_RESOLVE, ST_HALT
  } dm_state_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic clash;
  } dm_req_t;

  // Tap indices must rise from low through center to high.
  function automatic logic taps_ordered(input int unsigned lo,
                                        input int unsigned ctr,
                                        input int unsigned hi);
    return (lo <= ctr) && (ctr <= hi);
  endfunction

  // Slow takes priority: raise when slow, lower only when fast alone.
  function automatic dm_req_t req_decode(input logic slow, input logic fast);
    dm_req_t r;
    r.up    = slow;
    r.dn    = fast & ~slow;
    r.clash = fast & slow;
    return r;
  endfunction

endpackage

// File: rtl/dm_ivl_timer.sv
module dm_ivl_timer #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pre <= '0;
    end else if (load) begin
      cnt <= cnt_val;
      pre <= pre_val;
    end else if (run && cnt != '0) begin
      if (pre == '0) begin
        pre <= pre_val;
        cnt <= cnt - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign zero = (cnt == '0);

  // R1: an expired counter never wraps while running
  a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && zero && !load |=> zero);
  // R1: main count only moves when the prescaler is exhausted
  a_r1_pace: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && pre != '0 |=> $stable(cnt));

endmodule

// File: rtl/dm_line_cap.sv
module dm_line_cap #(
  parameter int TAP_W  = 5,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [TAP_W-1:0]  lo_idx,
  input  logic [TAP_W-1:0]  ctr_idx,
  input  logic [TAP_W-1:0]  hi_idx,
  input  logic [WAIT_W-1:0] wait_sel,
  input  logic [WAIT_W-1:0] wc,
  input  logic              in_wait,
  input  logic              tap_lo,
  input  logic              tap_ctr,
  input  logic              tap_hi,
  output logic              smp_lo,
  output logic              smp_ctr,
  output logic              smp_hi,
  output logic              counted,
  output logic              bad
);
  import dm_pkg::*;

  logic ordered;
  logic cap_now;

  assign ordered = taps_ordered(32'(lo_idx), 32'(ctr_idx), 32'(hi_idx));
  assign counted = act & ordered;
  assign bad     = act & ~ordered;
  assign cap_now = in_wait && (wc == wait_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_lo  <= 1'b0;
      smp_ctr <= 1'b0;
      smp_hi  <= 1'b0;
    end else if (cap_now) begin
      smp_lo  <= tap_lo;
      smp_ctr <= tap_ctr;
      smp_hi  <= tap_hi;
    end
  end

  // R4: samples only move on this line's capture cycle
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_now |=> $stable({smp_lo, smp_ctr, smp_hi}));
  // R5: a line is never both counted and flagged bad
  a_r5_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(counted && bad));

endmodule

// File: rtl/dm_merge.sv
module dm_merge #(
  parameter int LINES = 5
) (
  input  logic [LINES-1:0] counted,
  input  logic [LINES-1:0] smp_lo,
  input  logic [LINES-1:0] smp_hi,
  input  logic             any_hi,
  output logic             slow,
  output logic             fast
);
  logic fast_all;
  logic fast_any;

  assign slow     = |(counted & ~smp_lo);
  assign fast_any = |(counted & smp_hi);
  assign fast_all = (|counted) && (&(smp_hi | ~counted));
  assign fast     = any_hi ? fast_any : fast_all;

  always_comb begin
    // R7: with no counted line the fast flag stays low
    a_r7_none: assert (|counted || !fast);
    // R6: slow requires a counted line
    a_r6_src: assert (|counted || !slow);
  end

endmodule

// File: rtl/dly_mon_decide.sv
module dly_mon_decide #(
  parameter int LINES  = 5,
  parameter int TAP_W  = 5,
  parameter int CRS_W  = 3,
  parameter int WAIT_W = 2,
  parameter int IVL_W  = 24,
  parameter int PRE_W  = 8,
  parameter int REF_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mon_en,
  input  logic                    one_shot,
  input  logic                    prime_en,
  input  logic                    any_hi,
  input  logic [REF_W-1:0]        ref_sel,
  input  logic [PRE_W-1:0]        ivl_pre,
  input  logic [IVL_W-1:0]        ivl_cnt,
  input  logic [LINES-1:0]        line_act,
  input  logic [LINES*TAP_W-1:0]  lo_idx,
  input  logic [LINES*TAP_W-1:0]  ctr_idx,
  input  logic [LINES*TAP_W-1:0]  hi_idx,
  input  logic [LINES*CRS_W-1:0]  coarse_cfg,
  input  logic [LINES*WAIT_W-1:0] wait_cfg,
  input  logic [LINES-1:0]        tap_lo,
  input  logic [LINES-1:0]        tap_ctr,
  input  logic [LINES-1:0]        tap_hi,
  output logic                    prime,
  output logic                    launch,
  output logic [LINES*CRS_W-1:0]  dl_coarse,
  output logic                    ivl_zero,
  output logic [LINES-1:0]        smp_lo,
  output logic [LINES-1:0]        smp_ctr,
  output logic [LINES-1:0]        smp_hi,
  output logic                    slow_trip,
  output logic                    fast_trip,
  output logic                    ref_ctr,
  output logic                    up_req,
  output logic                    dn_req,
  output logic                    adj_err,
  output logic                    range_err,
  output logic                    ref_err,
  output logic                    valid_tap
);
  import dm_pkg::*;

  localparam logic [WAIT_W-1:0] WC_LAST = '1;

  dm_state_e         st, st_nx;
  logic [WAIT_W-1:0] wc;
  logic              tmr_load, tmr_run, in_wait, resolve, expire;
  logic [LINES-1:0]  counted, bad;
  logic              slow_c, fast_c, ref_pick;
  dm_req_t           req_c;
  logic              meas_busy;

  // ---------------- sequencer ----------------
  always_comb begin
    st_nx    = st;
    tmr_load = 1'b0;
    unique case (st)
      ST_IDLE:    begin st_nx = ST_COUNT; tmr_load = 1'b1; end
      ST_COUNT:   if (ivl_zero) st_nx = prime_en ? ST_PRIME : ST_LAUNCH;
      ST_PRIME:   st_nx = ST_LAUNCH;
      ST_LAUNCH:  st_nx = ST_WAIT;
      ST_WAIT:    if (wc == WC_LAST) st_nx = ST_RESOLVE;
      ST_RESOLVE: begin
        st_nx    = one_shot ? ST_HALT : ST_COUNT;
        tmr_load = !one_shot;
      end
      ST_HALT:    st_nx = ST_HALT;
      default:    st_nx = ST_IDLE;
    endcase
    if (!mon_en) begin
      st_nx    = ST_IDLE;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      wc <= '0;
    end else begin
      st <= st_nx;
      wc <= (st == ST_WAIT) ? wc + 1'b1 : '0;
    end
  end

  assign tmr_run   = (st == ST_COUNT);
  assign expire    = tmr_run && ivl_zero && mon_en;
  assign in_wait   = (st == ST_WAIT);
  assign resolve   = (st == ST_RESOLVE) && mon_en;
  assign prime     = (st == ST_PRIME);
  assign launch    = (st == ST_LAUNCH);
  assign meas_busy = (st == ST_PRIME) || (st == ST_LAUNCH) || in_wait || (st == ST_RESOLVE);

  dm_ivl_timer #(.CNT_W(IVL_W), .PRE_W(PRE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run),
    .pre_val(ivl_pre), .cnt_val(ivl_cnt), .zero(ivl_zero)
  );

  // ---------------- per-line capture ----------------
  for (genvar i = 0; i < LINES; i++) begin : g_line
    dm_line_cap #(.TAP_W(TAP_W), .WAIT_W(WAIT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .act(line_act[i]),
      .lo_idx(lo_idx[i*TAP_W +: TAP_W]),
      .ctr_idx(ctr_idx[i*TAP_W +: TAP_W]),
      .hi_idx(hi_idx[i*TAP_W +: TAP_W]),
      .wait_sel(wait_cfg[i*WAIT_W +: WAIT_W]),
      .wc(wc), .in_wait(in_wait),
      .tap_lo(tap_lo[i]), .tap_ctr(tap_ctr[i]), .tap_hi(tap_hi[i]),
      .smp_lo(smp_lo[i]), .smp_ctr(smp_ctr[i]), .smp_hi(smp_hi[i]),
      .counted(counted[i]), .bad(bad[i])
    );
  end

  // ---------------- merge and decide ----------------
  dm_merge #(.LINES(LINES)) u_merge (
    .counted(counted), .smp_lo(smp_lo), .smp_hi(smp_hi),
    .any_hi(any_hi), .slow(slow_c), .fast(fast_c)
  );

  assign req_c = req_decode(slow_c, fast_c);

  always_comb begin
    ref_pick = 1'b0;
    for (int i = 0; i < LINES; i++)
      if (ref_sel == REF_W'(i)) ref_pick = smp_ctr[i];
  end

  assign ref_err   = (32'(ref_sel) >= LINES);
  assign range_err = |bad;
  assign valid_tap = |line_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_trip <= 1'b0;
      fast_trip <= 1'b0;
      up_req    <= 1'b0;
      dn_req    <= 1'b0;
      adj_err   <= 1'b0;
      ref_ctr   <= 1'b0;
      dl_coarse <= '0;
    end else begin
      if (expire) dl_coarse <= coarse_cfg;
      if (resolve) begin
        slow_trip <= slow_c;
        fast_trip <= fast_c;
        up_req    <= req_c.up;
        dn_req    <= req_c.dn;
        adj_err   <= req_c.clash;
        ref_ctr   <= ref_pick;
      end
    end
  end

  // R8: raise and lower are never requested together
  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_req && dn_req));
  // R8: a conflict always coincides with a raise request
  a_r8_clash_up: assert property (@(posedge clk) disable iff (!rst_n)
    adj_err |-> up_req && fast_trip);
  // R3: the priming pulse is followed by the launch
  a_r3_prime_then_launch: assert property (@(posedge clk) disable iff (!rst_n)
    prime && mon_en |=> launch);
  // R1: launch only follows an expired interval
  a_r1_launch_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> $past(ivl_zero));
  // R10: coarse snapshot steady during a measurement
  a_r10_coarse_steady: assert property (@(posedge clk) disable iff (!rst_n)
    meas_busy && $past(meas_busy) |-> $stable(dl_coarse));

endmodule

// File: tb/tb_dly_mon_decide.sv
`timescale 1ns/1ps
module tb_dly_mon_decide;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mon_en = 0, one_shot = 0, prime_en = 0, any_hi = 0;
  logic [3:0]  ref_sel = '0;
  logic [7:0]  ivl_pre = '0;
  logic [23:0] ivl_cnt = '0;
  logic [N-1:0] line_act = '0;
  logic [N*5-1:0] lo_idx = '0, ctr_idx = '0, hi_idx = '0;
  logic [N*3-1:0] coarse_cfg = '0;
  logic [N*2-1:0] wait_cfg = '0;
  logic [N-1:0] tap_lo = '0, tap_ctr = '0, tap_hi = '0;
  logic prime, launch, ivl_zero, slow_trip, fast_trip, ref_ctr;
  logic up_req, dn_req, adj_err, range_err, ref_err, valid_tap;
  logic [N*3-1:0] dl_coarse;
  logic [N-1:0] smp_lo, smp_ctr, smp_hi;

  int n_chk = 0, n_fail = 0;
  int pushed = 0, popped = 0;

  typedef struct {
    logic [5:0] res;   // {slow, fast, up, dn, adj, refc}
    logic [N-1:0] lo;
    logic [N-1:0] hi;
    string tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #10 clk = ~clk;

  dly_mon_decide dut (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .one_shot(one_shot),
    .prime_en(prime_en), .any_hi(any_hi), .ref_sel(ref_sel),
    .ivl_pre(ivl_pre), .ivl_cnt(ivl_cnt), .line_act(line_act),
    .lo_idx(lo_idx), .ctr_idx(ctr_idx), .hi_idx(hi_idx),
    .coarse_cfg(coarse_cfg), .wait_cfg(wait_cfg),
    .tap_lo(tap_lo), .tap_ctr(tap_ctr), .tap_hi(tap_hi),
    .prime(prime), .launch(launch), .dl_coarse(dl_coarse),
    .ivl_zero(ivl_zero), .smp_lo(smp_lo), .smp_ctr(smp_ctr),
    .smp_hi(smp_hi), .slow_trip(slow_trip), .fast_trip(fast_trip),
    .ref_ctr(ref_ctr), .up_req(up_req), .dn_req(dn_req),
    .adj_err(adj_err), .range_err(range_err), .ref_err(ref_err),
    .valid_tap(valid_tap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_line(input int i, input logic a, input int lo, input int c, input int hi);
    line_act[i] = a;
    lo_idx[i*5 +: 5]  = 5'(lo);
    ctr_idx[i*5 +: 5] = 5'(c);
    hi_idx[i*5 +: 5]  = 5'(hi);
  endtask

  // Independent model of the decision from the requirements.
  function automatic logic [5:0] model();
    logic s, f_all, f_any, any, f, rc;
    s = 0; f_all = 1; f_any = 0; any = 0;
    for (int i = 0; i < N; i++) begin
      int l, c, h;
      l = int'(lo_idx[i*5 +: 5]); c = int'(ctr_idx[i*5 +: 5]); h = int'(hi_idx[i*5 +: 5]);
      if (line_act[i] && l <= c && c <= h) begin
        any = 1;
        if (!tap_lo[i]) s = 1;
        if (tap_hi[i]) f_any = 1; else f_all = 0;
      end
    end
    f  = any && (any_hi ? f_any : f_all);
    rc = (int'(ref_sel) < N) ? tap_ctr[ref_sel] : 1'b0;
    return {s, f, s, f & ~s, s & f, rc};
  endfunction

  task automatic sb_run(input string tag);
    sb_item_t it;
    it.res = model(); it.lo = tap_lo; it.hi = tap_hi; it.tag = tag;
    sbq.push_back(it);
    pushed++;
    if (!mon_en) mon_en = 1;
    wait (popped == pushed);
  endtask

  // Monitor: results appear six cycles after the launch cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (launch && rst_n) begin
        repeat (6) @(negedge clk);
        if (sbq.size() > 0) begin
          sb_item_t it;
          it = sbq.pop_front();
          chk({it.tag, " R8 results"}, 32'({slow_trip, fast_trip, up_req, dn_req, adj_err, ref_ctr}), 32'(it.res));
          chk({it.tag, " R4 samples"}, 32'({smp_lo, smp_hi}), 32'({it.lo, it.hi}));
          popped++;
        end
      end
    end
  end

  task automatic wait_launch();
    do @(negedge clk); while (!launch);
  endtask

  task automatic gap_check(input string tag, input int exp, input logic exp_prime);
    int n;
    logic pr_seen, pr_last;
    wait_launch();
    n = 0; pr_seen = 0; pr_last = 0;
    do begin
      pr_last = prime;
      @(negedge clk);
      n++;
      if (prime) pr_seen = 1;
    end while (!launch);
    chk({tag, " R1 launch gap"}, 32'(n), 32'(exp));
    chk({tag, " R3 prime seen"}, 32'(pr_seen), 32'(exp_prime));
    if (exp_prime) chk({tag, " R3 prime before launch"}, 32'(pr_last), 32'(1));
  endtask

  task automatic stop_mon();
    mon_en = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset results", 32'({slow_trip, fast_trip, up_req, dn_req, adj_err, ref_ctr, prime, launch}), 32'(0));
    chk("R11 reset samples", 32'({smp_lo, smp_ctr, smp_hi, dl_coarse}), 32'(0));
    chk("R1 zero out of reset", 32'(ivl_zero), 32'(1));

    // R1 interval pacing
    for (int i = 0; i < N; i++) set_line(i, 1, 2, 8, 20);
    tap_lo = '1;
    ivl_cnt = 24'd3; ivl_pre = 8'd2;
    mon_en = 1;
    @(negedge clk);
    chk("R1 zero clear after load", 32'(ivl_zero), 32'(1'b0));
    gap_check("C3P2", 3 * 3 + 7, 1'b0);
    stop_mon();
    prime_en = 1; mon_en = 1;
    gap_check("C3P2 prime", 3 * 3 + 8, 1'b1);
    stop_mon();
    prime_en = 0; ivl_cnt = 24'd0; ivl_pre = 8'd5; mon_en = 1;
    gap_check("C0P5", 7, 1'b0);
    stop_mon();

    // R11 abort: drop enable mid-count
    begin
      int nl;
      ivl_cnt = 24'd5; ivl_pre = 8'd3; mon_en = 1;
      repeat (3) @(negedge clk);
      mon_en = 0; nl = 0;
      repeat (60) begin @(negedge clk); if (launch) nl++; end
      chk("R11 no launch while disabled", 32'(nl), 32'(0));
    end

    // R2 one-shot
    begin
      int nl;
      one_shot = 1; ivl_cnt = 24'd1; ivl_pre = 8'd0; mon_en = 1; nl = 0;
      repeat (60) begin @(negedge clk); if (launch) nl++; end
      chk("R2 single launch", 32'(nl), 32'(1));
      stop_mon();
      one_shot = 0;
    end

    // R4 per-line wait: taps rise in the middle of cycle L+2
    wait_cfg = '0;
    wait_cfg[1*2 +: 2] = 2'd1;
    wait_cfg[2*2 +: 2] = 2'd3;
    tap_ctr = '0; ivl_cnt = 24'd2; ivl_pre = 8'd1; mon_en = 1;
    wait_launch();
    @(negedge clk); @(negedge clk);
    tap_ctr = '1;
    repeat (5) @(negedge clk);
    chk("R4 wait-dependent capture", 32'(smp_ctr), 32'(5'b00110));
    stop_mon();
    wait_cfg = '0; tap_ctr = '0;

    // R10 coarse snapshot
    coarse_cfg = {N{3'd5}}; mon_en = 1;
    wait_launch();
    coarse_cfg = {N{3'd2}};
    repeat (3) @(negedge clk);
    chk("R10 coarse held", 32'(dl_coarse), 32'({N{3'd5}}));
    wait_launch();
    chk("R10 coarse next", 32'(dl_coarse), 32'({N{3'd2}}));
    stop_mon();

    // R5 / R9 combinational status
    line_act = '0; #1;
    chk("R5 valid none", 32'(valid_tap), 32'(0));
    set_line(3, 1, 4, 9, 12); #1;
    chk("R5 valid one", 32'({valid_tap, range_err}), 32'(2'b10));
    set_line(3, 1, 10, 9, 12); #1;
    chk("R5 range error", 32'(range_err), 32'(1));
    set_line(3, 1, 4, 9, 8); #1;
    chk("R5 range error hi", 32'(range_err), 32'(1));
    ref_sel = 4'd5; #1;
    chk("R9 ref error", 32'(ref_err), 32'(1));
    ref_sel = 4'd4; #1;
    chk("R9 ref ok", 32'(ref_err), 32'(0));
    ref_sel = '0;

    // Scoreboard runs in continuous mode
    for (int i = 0; i < N; i++) set_line(i, 1, 2, 8, 20);
    ivl_cnt = 24'd2; ivl_pre = 8'd1;
    tap_lo = '1; tap_hi = '0;
    sb_run("R6 R7 all nominal");
    tap_hi = '1;
    sb_run("R7 all fast lower");
    tap_lo = 5'b11011;
    sb_run("R6 R8 slow and fast clash");
    tap_lo = '1; tap_hi = 5'b01000; any_hi = 1;
    sb_run("R7 any-high single line");
    any_hi = 0;
    sb_run("R7 all-high single line");
    set_line(3, 1, 9, 8, 20); tap_lo = 5'b10111; tap_hi = 5'b10111;
    sb_run("R5 disordered line excluded");
    set_line(3, 1, 2, 8, 20); tap_lo = '1; tap_hi = '0;
    tap_ctr = 5'b00100; ref_sel = 4'd2;
    sb_run("R9 reference center");
    ref_sel = 4'd7;
    sb_run("R9 reference out of range");
    line_act = '0; tap_lo = '0; tap_hi = '1; ref_sel = '0;
    sb_run("R5 R7 no counted line");
    stop_mon();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule